// File: doc/BRIEF.md
# Next-Fetch-Address Predictor (Global-History Direction Table plus Target Buffer)

This block tells the fetch stage where to fetch next. Each cycle it looks at the current fetch address and, without a clock edge in between, returns a predicted next address. The prediction joins two structures. One is a direction table of two-bit saturating counters, indexed by the global branch history XORed with the fetch address. The other is a direct-mapped target buffer that records which addresses hold branches, where they go, and whether they are unconditional.

The execute stage reports every resolved branch through an update port. The report carries the branch address, whether it is unconditional, its actual outcome and its actual destination. Conditional reports train a counter and shift the outcome into the history. Every report, conditional or not, rewrites the branch's target buffer entry. All table writes take effect on the clock edge that samples the report. The asynchronous active-low reset is synchronised inside the block before it is released.

Top module: `nextpc_predictor`

## Requirements
- R1: The global history is 8 bits wide. A conditional update shifts it left by one and places the outcome in bit 0, with taken written as 1 and not-taken as 0. The oldest bit is dropped.
- R2: The counter is chosen by the history XORed with address bits [9:2]. For lookups the address is the fetch address. For updates it is the branch address, XORed with the history as it stands before that update's shift.
- R3: Counters encode 00 strongly not-taken, 01 weakly not-taken, 10 weakly taken and 11 strongly taken, and bit 1 is the prediction. A taken outcome adds one and a not-taken outcome subtracts one. A counter at 11 stays at 11, and a counter at 00 stays at 00.
- R4: The target buffer has 1024 direct-mapped entries selected by address bits [11:2]. An entry hits only when it is valid and its stored 32-bit address equals the whole fetch address.
- R5: On a target buffer miss the prediction is the fetch address plus 4, whatever the counter holds. The sum wraps modulo 2^32.
- R6: On a hit, the prediction is the stored destination if the entry is unconditional. It is also the stored destination if the entry is conditional and the selected counter predicts taken. In every other hit case the prediction is the fetch address plus 4.
- R7: An unconditional update writes only its target buffer entry, with the unconditional flag set. The history and every counter keep their values.
- R8: After reset every counter is 00, every target buffer entry is invalid and the history is zero. Every fetch address then predicts address plus 4.
- R9: A conditional update writes its target buffer entry whether the branch was taken or not. The entry gets the branch address as tag, the reported destination and a cleared unconditional flag. It replaces whatever entry sat at that index before, including an unconditional one.
- R10: While upd_valid is low, the other update inputs change nothing in the history, the counters or the target buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all table writes happen on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, synchronised internally before release |
| fetch_pc | input | 32 | Current fetch address to predict from |
| pred_npc | output | 32 | Predicted next fetch address, combinational from fetch_pc and the tables |
| upd_valid | input | 1 | A resolved branch report is present this cycle |
| upd_pc | input | 32 | Address of the resolved branch |
| upd_uncond | input | 1 | 1 when the resolved branch is unconditional |
| upd_taken | input | 1 | Actual outcome of a conditional branch, 1 = taken |
| upd_target | input | 32 | Actual destination address of the branch |

## Verification
The bench goes after the counter ends. A counter that wraps from 00 would predict taken after one not-taken outcome, and a counter that wraps from 11 would fall to not-taken under a run of taken outcomes. It also checks that training uses the history from before the shift: a design that indexes the update with the shifted history moves the counter too early and predicts taken one report too soon. Two buffer cases are covered. Aliased addresses that share an index but differ in tag must miss, because a partial tag compare would hand one branch the other's destination. An unconditional report must leave the history alone, since a shifted history moves later lookups to an untrained counter. A long mixed stream of conditional and unconditional reports over aliasing addresses is compared against a model built from the requirements.

// File: rtl/bp_pkg.sv
package bp_pkg;

  // Two-bit direction counter; bit 1 is the taken/not-taken verdict.
  typedef enum logic [1:0] {
    CTR_SNT = 2'b00,
    CTR_WNT = 2'b01,
    CTR_WT  = 2'b10,
    CTR_ST  = 2'b11
  } ctr_t;

  // Saturating step toward the observed outcome.
  function automatic ctr_t ctr_step(input ctr_t cur, input logic taken);
    logic [1:0] raw;
    raw = cur;
    if (taken && (raw != 2'b11)) begin
      raw = raw + 2'd1;
    end else if (!taken && (raw != 2'b00)) begin
      raw = raw - 2'd1;
    end
    return ctr_t'(raw);
  endfunction

endpackage

// File: rtl/bp_ghr.sv
module bp_ghr #(
  parameter int HIST_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              shift_bit,
  output logic [HIST_W-1:0] hist_q
);

  logic [HIST_W-1:0] hist_d;

  always_comb begin
    hist_d = hist_q;
    if (shift_en) begin
      hist_d = {hist_q[HIST_W-2:0], shift_bit};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '0;
    end else if (shift_en) begin
      hist_q <= hist_d;
    end
  end

endmodule

// File: rtl/bp_pht.sv
module bp_pht
  import bp_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_taken,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_taken
);

  localparam int DEPTH = 1 << IDX_W;

  logic [2*DEPTH-1:0] ctr_flat;

  for (genvar g = 0; g < DEPTH; g++) begin : g_ctr
    ctr_t cq;
    ctr_t cd;
    logic sel_w;

    assign sel_w = wr_en && (wr_idx == IDX_W'(g));

    always_comb begin
      cd = cq;
      if (sel_w) begin
        cd = ctr_step(cq, wr_taken);
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cq <= CTR_SNT;
      end else if (sel_w) begin
        cq <= cd;
      end
    end

    assign ctr_flat[2*g +: 2] = cq;
  end

  // Upper bit of the selected counter is the direction verdict.
  assign rd_taken = ctr_flat[{rd_idx, 1'b1}];

endmodule

// File: rtl/bp_btb.sv
module bp_btb #(
  parameter int PC_W  = 32,
  parameter int IDX_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic [PC_W-1:0]  rd_pc,
  output logic             rd_hit,
  output logic             rd_uncond,
  output logic [PC_W-1:0]  rd_target,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [PC_W-1:0]  wr_pc,
  input  logic             wr_uncond,
  input  logic [PC_W-1:0]  wr_target
);

  localparam int DEPTH = 1 << IDX_W;
  localparam int PAY_W = 2 * PC_W + 1;

  logic [DEPTH-1:0] vld_q;
  logic [DEPTH-1:0] vld_d;
  logic [PAY_W-1:0] pay_q [DEPTH];
  logic [PAY_W-1:0] wr_pay;
  logic [PAY_W-1:0] rd_pay;

  // Valid bits carry the reset; payload needs none because it is masked.
  always_comb begin
    vld_d = vld_q;
    if (wr_en) begin
      vld_d[wr_idx] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
    end else if (wr_en) begin
      vld_q <= vld_d;
    end
  end

  assign wr_pay = {wr_uncond, wr_pc, wr_target};

  always_ff @(posedge clk) begin
    if (wr_en) begin
      pay_q[wr_idx] <= wr_pay;
    end
  end

  assign rd_pay    = pay_q[rd_idx];
  assign rd_hit    = vld_q[rd_idx] && (rd_pay[PC_W +: PC_W] == rd_pc);
  assign rd_uncond = rd_pay[2*PC_W];
  assign rd_target = rd_pay[PC_W-1:0];

endmodule

// File: rtl/nextpc_predictor.sv
module nextpc_predictor #(
  parameter int PC_W      = 32,
  parameter int HIST_W    = 8,
  parameter int BTB_IDX_W = 10,
  parameter int ALIGN_LG  = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] fetch_pc,
  output logic [PC_W-1:0] pred_npc,
  input  logic            upd_valid,
  input  logic [PC_W-1:0] upd_pc,
  input  logic            upd_uncond,
  input  logic            upd_taken,
  input  logic [PC_W-1:0] upd_target
);

  localparam int PC_STEP = 1 << ALIGN_LG;

  // Reset: asserted asynchronously, released after two clock edges.
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end

  assign rst_sync_n = rst_pipe_q[1];

  // Update decode.
  logic upd_cond_en;
  logic upd_btb_en;

  assign upd_cond_en = upd_valid && !upd_uncond;
  assign upd_btb_en  = upd_valid;

  // Global history.
  logic [HIST_W-1:0] hist_q;

  bp_ghr #(
    .HIST_W (HIST_W)
  ) u_ghr (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .shift_en  (upd_cond_en),
    .shift_bit (upd_taken),
    .hist_q    (hist_q)
  );

  // Direction table: lookup and training both hash with the current history.
  logic [HIST_W-1:0] lk_pht_idx;
  logic [HIST_W-1:0] up_pht_idx;
  logic              pht_taken;

  assign lk_pht_idx = hist_q ^ fetch_pc[ALIGN_LG +: HIST_W];
  assign up_pht_idx = hist_q ^ upd_pc[ALIGN_LG +: HIST_W];

  bp_pht #(
    .IDX_W (HIST_W)
  ) u_pht (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .rd_idx   (lk_pht_idx),
    .rd_taken (pht_taken),
    .wr_en    (upd_cond_en),
    .wr_idx   (up_pht_idx),
    .wr_taken (upd_taken)
  );

  // Target buffer.
  logic [BTB_IDX_W-1:0] lk_btb_idx;
  logic [BTB_IDX_W-1:0] up_btb_idx;
  logic                 lk_hit;
  logic                 lk_uncond;
  logic [PC_W-1:0]      lk_target;

  assign lk_btb_idx = fetch_pc[ALIGN_LG +: BTB_IDX_W];
  assign up_btb_idx = upd_pc[ALIGN_LG +: BTB_IDX_W];

  bp_btb #(
    .PC_W  (PC_W),
    .IDX_W (BTB_IDX_W)
  ) u_btb (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .rd_idx    (lk_btb_idx),
    .rd_pc     (fetch_pc),
    .rd_hit    (lk_hit),
    .rd_uncond (lk_uncond),
    .rd_target (lk_target),
    .wr_en     (upd_btb_en),
    .wr_idx    (up_btb_idx),
    .wr_pc     (upd_pc),
    .wr_uncond (upd_uncond),
    .wr_target (upd_target)
  );

  // Next-address selection.
  logic [PC_W-1:0] seq_pc;

  assign seq_pc = fetch_pc + PC_W'(PC_STEP);

  always_comb begin
    pred_npc = seq_pc;
    if (lk_hit && (lk_uncond || pht_taken)) begin
      pred_npc = lk_target;
    end
  end

endmodule

// File: rtl/bp_checker.sv
module bp_checker #(
  parameter int PC_W     = 32,
  parameter int HIST_W   = 8,
  parameter int ALIGN_LG = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [PC_W-1:0]   fetch_pc,
  input logic [PC_W-1:0]   pred_npc,
  input logic              upd_valid,
  input logic              upd_uncond,
  input logic              upd_taken,
  input logic [HIST_W-1:0] hist_q,
  input logic              lk_hit,
  input logic              lk_uncond,
  input logic [PC_W-1:0]   lk_target
);

  localparam int PC_STEP = 1 << ALIGN_LG;

  // R5: a miss always falls through to the sequential address.
  p_miss_seq_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> (pred_npc == fetch_pc + PC_W'(PC_STEP)));

  // R6: an unconditional hit always redirects.
  p_uncond_hit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_hit && lk_uncond) |-> (pred_npc == lk_target));

  // R1: a conditional report shifts its outcome into bit 0.
  p_hist_shift_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && !upd_uncond) |=>
      (hist_q == {$past(hist_q[HIST_W-2:0]), $past(upd_taken)}));

  // R7: an unconditional report leaves the history alone.
  p_hist_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && upd_uncond) |=> $stable(hist_q));

  // R10: no report, no history change.
  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_valid |=> $stable(hist_q));

endmodule

bind nextpc_predictor bp_checker #(
  .PC_W     (PC_W),
  .HIST_W   (HIST_W),
  .ALIGN_LG (ALIGN_LG)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .fetch_pc   (fetch_pc),
  .pred_npc   (pred_npc),
  .upd_valid  (upd_valid),
  .upd_uncond (upd_uncond),
  .upd_taken  (upd_taken),
  .hist_q     (hist_q),
  .lk_hit     (lk_hit),
  .lk_uncond  (lk_uncond),
  .lk_target  (lk_target)
);

// File: tb/tb_nextpc_predictor.sv
module tb_nextpc_predictor;

  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic [31:0] fetch_pc;
  logic [31:0] pred_npc;
  logic        upd_valid;
  logic [31:0] upd_pc;
  logic        upd_uncond;
  logic        upd_taken;
  logic [31:0] upd_target;

  nextpc_predictor dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .fetch_pc   (fetch_pc),
    .pred_npc   (pred_npc),
    .upd_valid  (upd_valid),
    .upd_pc     (upd_pc),
    .upd_uncond (upd_uncond),
    .upd_taken  (upd_taken),
    .upd_target (upd_target)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int n_checks = 0;
  int n_fail   = 0;

  // Reference model built from the requirements.
  bit [1:0]  m_pht [256];
  bit [7:0]  m_hist;
  bit        m_val [1024];
  bit        m_unc [1024];
  bit [31:0] m_tag [1024];
  bit [31:0] m_tgt [1024];

  function automatic bit [31:0] model_npc(input bit [31:0] pc);
    bit [9:0] bi;
    bit [7:0] pi;
    bi = pc[11:2];
    pi = pc[9:2] ^ m_hist;
    if (m_val[bi] && (m_tag[bi] == pc)) begin
      if (m_unc[bi] || m_pht[pi][1]) return m_tgt[bi];
    end
    return pc + 32'd4;
  endfunction

  task automatic check_eq(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic probe(input logic [31:0] pc, input logic [31:0] exp, input string rq);
    @(negedge clk);
    fetch_pc = pc;
    #1;
    check_eq(rq, pred_npc, exp);
  endtask

  task automatic probe_model(input logic [31:0] pc, input string rq);
    probe(pc, model_npc(pc), rq);
  endtask

  task automatic do_reset();
    rst_n     = 1'b0;
    upd_valid = 1'b0;
    upd_pc = '0; upd_uncond = 1'b0; upd_taken = 1'b0; upd_target = '0;
    fetch_pc  = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    m_hist = '0;
    for (int i = 0; i < 256; i++) m_pht[i] = 2'b00;
    for (int i = 0; i < 1024; i++) begin
      m_val[i] = 1'b0; m_unc[i] = 1'b0; m_tag[i] = '0; m_tgt[i] = '0;
    end
  endtask

  task automatic do_update(input logic [31:0] pc, input logic unc, input logic tk,
                           input logic [31:0] tgt);
    bit [7:0] pi;
    @(negedge clk);
    upd_valid = 1'b1; upd_pc = pc; upd_uncond = unc; upd_taken = tk; upd_target = tgt;
    @(posedge clk);
    #1;
    upd_valid = 1'b0;
    if (!unc) begin
      pi = pc[9:2] ^ m_hist;
      if (tk && m_pht[pi] != 2'b11) m_pht[pi] = m_pht[pi] + 2'd1;
      else if (!tk && m_pht[pi] != 2'b00) m_pht[pi] = m_pht[pi] - 2'd1;
      m_hist = {m_hist[6:0], tk};
    end
    m_val[pc[11:2]] = 1'b1;
    m_unc[pc[11:2]] = unc;
    m_tag[pc[11:2]] = pc;
    m_tgt[pc[11:2]] = tgt;
  endtask

  // R8 / R5: everything predicts the sequential address after reset.
  task automatic t_reset();
    do_reset();
    probe(32'h0000_0000, 32'h0000_0004, "R8 reset zero");
    probe(32'h0000_0100, 32'h0000_0104, "R8 reset 0x100");
    probe(32'hFFFF_FFFC, 32'h0000_0000, "R5 wrap");
  endtask

  // R6 / R4 / R5: unconditional entry and an aliased address.
  task automatic t_uncond_alias();
    do_reset();
    do_update(32'h0000_0100, 1'b1, 1'b1, 32'h0000_2000);
    probe(32'h0000_0100, 32'h0000_2000, "R6 uncond hit");
    probe(32'h0000_1100, 32'h0000_1104, "R4 alias tag mismatch");
    probe(32'h8000_0100, 32'h8000_0104, "R4 high-bit tag mismatch");
    probe(32'h0000_0104, 32'h0000_0108, "R5 neighbour miss");
  endtask

  // R3 / R2 / R7 / R10: upper saturation, pre-shift training index.
  task automatic t_saturate_high();
    logic [31:0] a = 32'h0000_0400;
    logic [31:0] ta = 32'h0000_5000;
    do_reset();
    for (int k = 1; k <= 9; k++) do_update(a, 1'b0, 1'b1, ta);
    probe(a, a + 32'd4, "R2 pre-shift index, counter 01 not taken");
    do_update(a, 1'b0, 1'b1, ta);
    probe(a, ta, "R3 counter 10 predicts taken");
    do_update(a, 1'b0, 1'b1, ta);
    do_update(a, 1'b0, 1'b1, ta);
    probe(a, ta, "R3 counter saturated at 11");
    do_update(32'h0000_0800, 1'b1, 1'b1, 32'h0000_9000);
    probe(a, ta, "R7 history untouched by uncond update");
    probe(32'h0000_0800, 32'h0000_9000, "R7 uncond entry written");
    // Idle cycle with a not-taken report on the bus but no valid.
    @(negedge clk);
    upd_pc = a; upd_uncond = 1'b0; upd_taken = 1'b0; upd_target = 32'h0000_0BAD;
    @(negedge clk);
    probe(a, ta, "R10 ignored report keeps history and counter");
    probe(32'h0000_0800, 32'h0000_9000, "R10 ignored report keeps buffer");
    do_update(a, 1'b0, 1'b0, ta);
    probe(a, a + 32'd4, "R1 history shifted to 0xFE selects untrained counter");
    probe(a ^ 32'h0000_0004, (a ^ 32'h0000_0004) + 32'd4, "R5 other address misses");
  endtask

  // R3 lower saturation and R9 overwrite rules.
  task automatic t_saturate_low();
    logic [31:0] b = 32'h0000_0600;
    logic [31:0] c = 32'h0000_0A00;
    do_reset();
    do_update(b, 1'b0, 1'b0, 32'h0000_7000);
    probe(b, b + 32'd4, "R3 counter stays at 00");
    do_update(b, 1'b0, 1'b0, 32'h0000_7000);
    do_update(b, 1'b0, 1'b1, 32'h0000_7000);
    probe_model(b, "R3 after floor then taken");
    do_update(c, 1'b1, 1'b1, 32'h0000_B000);
    probe(c, 32'h0000_B000, "R9 uncond before overwrite");
    do_update(c, 1'b0, 1'b0, 32'h0000_B000);
    probe(c, c + 32'd4, "R9 cond not-taken write clears uncond flag");
    probe_model(c, "R9 model agreement");
  endtask

  // R1-to-R9 coverage through a long mixed stream versus the model.
  task automatic t_mixed_stream();
    logic [31:0] pcs [8];
    logic [15:0] lfsr = 16'hACE1;
    pcs[0] = 32'h0000_1000; pcs[1] = 32'h0000_2000; pcs[2] = 32'h0000_1008;
    pcs[3] = 32'h0000_100C; pcs[4] = 32'h0000_3010; pcs[5] = 32'h0000_1FFC;
    pcs[6] = 32'h0000_0040; pcs[7] = 32'h0000_0044;
    do_reset();
    for (int n = 0; n < 400; n++) begin
      int sel;
      logic unc, tk;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      sel = int'(lfsr[2:0]);
      unc = (sel == 6) || (lfsr[9:7] == 3'b000);
      tk  = (n % 100 < 60) ? (lfsr[3] | lfsr[4]) : (lfsr[3] & lfsr[4]);
      do_update(pcs[sel], unc, tk, pcs[sel] + 32'h100 * (sel + 1) + {20'd0, lfsr[15:12], 8'd0});
      for (int j = 0; j < 8; j++) probe_model(pcs[j], "R6 mixed stream prediction");
    end
  endtask

  initial begin
    t_reset();
    t_uncond_alias();
    t_saturate_high();
    t_saturate_low();
    t_mixed_stream();
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

endmodule